// File: doc/BRIEF.md
# Suspect Output Marker for a Linear Checking Array

A one-way linear array of processing elements checks its work only part of the time. Each element checks CHECKED consecutive cycles out of every PERIOD cycles, and neighbouring elements are staggered so that waves of checking move upstream through the array. With perfect detection, an error that is caught may still have travelled through a few unchecked elements before it reached the checker. This block takes one detection report and works out which earlier outputs could carry that error. It then lists them one per clock as (element, cycle) tags.

A report holds the index of the detecting element, the position of the detecting check within that element's checked run, and the current cycle number. The block first tags the detecting element in the current cycle. It then walks one step back along the diagonal per clock: the previous element in the previous cycle, and so on. The depth of the walk is min(element, ceil((PERIOD + position + 1) / CHECKED) - 2). The last tag carries a marker. While a walk is running, the block reports itself busy and drops any new report. Reports with an out-of-range element or position are dropped.

Top module: `suspect_marker`

## Requirements
- R1: One clock after a report is accepted, `tag_valid` is high with `tag_pe` equal to the reported element and `tag_cycle` equal to the reported cycle.
- R2: An accepted report produces exactly D+1 tags, where D = min(element, ceil((PERIOD+position+1)/CHECKED) - 2). With the defaults (PERIOD 13, CHECKED 3), position 0 or 1 gives a cap of 3 and position 2 gives a cap of 4.
- R3: Each tag after the first has an element index one lower and a cycle number one lower than the tag before it. The cycle number wraps modulo 2^CYC_W.
- R4: `tag_last` is high only together with the final tag of a walk. `tag_valid` is low in the clock after it.
- R5: The walk never goes past element 0. A report from element 0 yields a single tag, and that tag carries `tag_last`.
- R6: `busy` is high from the clock after acceptance up to and including the final tag. A report presented while `busy` is high is ignored and leaves the running walk unchanged.
- R7: A report whose position is CHECKED or more, or whose element is NUM_PE or more, is ignored: no tag appears and `busy` stays low.
- R8: After reset, `busy`, `tag_valid` and `tag_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Detection report present |
| req_pe | input | PE_W | Index of the detecting element |
| req_chk | input | IDX_W | Position of the detecting check within its checked run |
| req_cycle | input | CYC_W | Cycle number of the detection |
| busy | output | 1 | A walk is in progress; new reports are dropped |
| tag_valid | output | 1 | A suspect tag is presented |
| tag_pe | output | PE_W | Element index of the suspect output |
| tag_cycle | output | CYC_W | Cycle number of the suspect output |
| tag_last | output | 1 | Final tag of the current walk |

## Verification
A report is sampled on a rising edge. The first tag then sits on the outputs for the whole following clock, and tag k of the walk appears k clocks after that. The bench drives each report half a cycle before the accepting edge. It then reads every tag at the falling edge of the clock where that tag is due, and compares it with an element, cycle and last-flag that the bench computes itself. In the clock after the expected final tag, it confirms that `tag_valid` and `busy` have dropped. For dropped reports, it checks the same clock that would otherwise have held a first tag.

// File: rtl/suspect_mark_pkg.sv
package suspect_mark_pkg;

  // Integer ceiling of a / b for positive operands.
  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  // Index width that stays at least one bit wide.
  function automatic int idx_width(int count);
    return (count <= 2) ? 1 : $clog2(count);
  endfunction

endpackage

// File: rtl/sm_rst_sync.sv
module sm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;

endmodule

// File: rtl/sm_reach_table.sv
module sm_reach_table
  import suspect_mark_pkg::*;
#(
  parameter int PERIOD  = 13,
  parameter int CHECKED = 3,
  parameter int NUM_PE  = 10,
  parameter int PE_W    = 4,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0] chk_idx,
  input  logic [PE_W-1:0]  det_pe,
  output logic [PE_W-1:0]  reach,
  output logic             req_ok
);

  // Per-position cap on the backward walk, computed at elaboration.
  logic [PE_W-1:0] cap_tbl [CHECKED];
  logic [PE_W-1:0] cap;
  logic            chk_ok;
  logic            pe_ok;

  for (genvar g = 0; g < CHECKED; g++) begin : g_cap
    localparam int RAW  = ceil_div(PERIOD + g + 1, CHECKED) - 2;
    localparam int CLIP = (RAW > NUM_PE - 1) ? (NUM_PE - 1) : RAW;
    assign cap_tbl[g] = PE_W'(CLIP);
  end

  always_comb begin
    cap = '0;
    for (int g = 0; g < CHECKED; g++) begin
      if (int'(chk_idx) == g) cap = cap_tbl[g];
    end
  end

  // The walk also stops at the array edge: depth never exceeds the index.
  assign reach  = (cap < det_pe) ? cap : det_pe;
  assign chk_ok = (int'(chk_idx) < CHECKED);
  assign pe_ok  = (int'(det_pe) < NUM_PE);
  assign req_ok = chk_ok && pe_ok;

endmodule

// File: rtl/sm_walker.sv
module sm_walker #(
  parameter int PE_W  = 4,
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PE_W-1:0]  start_pe,
  input  logic [CYC_W-1:0] start_cycle,
  input  logic [PE_W-1:0]  start_reach,
  output logic             active,
  output logic [PE_W-1:0]  cur_pe,
  output logic [CYC_W-1:0] cur_cycle,
  output logic             last
);

  logic             active_q, active_d;
  logic [PE_W-1:0]  pe_q, pe_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [PE_W-1:0]  left_q, left_d;
  logic             load_en;

  assign last = active_q && (left_q == '0);

  always_comb begin
    active_d = active_q;
    pe_d     = pe_q;
    cyc_d    = cyc_q;
    left_d   = left_q;
    load_en  = 1'b0;
    if (active_q) begin
      load_en = 1'b1;
      if (left_q == '0) begin
        active_d = 1'b0;
      end else begin
        pe_d   = pe_q - 1'b1;
        cyc_d  = cyc_q - 1'b1;
        left_d = left_q - 1'b1;
      end
    end else if (start) begin
      load_en  = 1'b1;
      active_d = 1'b1;
      pe_d     = start_pe;
      cyc_d    = start_cycle;
      left_d   = start_reach;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pe_q     <= '0;
      cyc_q    <= '0;
      left_q   <= '0;
    end else if (load_en) begin
      active_q <= active_d;
      pe_q     <= pe_d;
      cyc_q    <= cyc_d;
      left_q   <= left_d;
    end
  end

  assign active    = active_q;
  assign cur_pe    = pe_q;
  assign cur_cycle = cyc_q;

endmodule

// File: rtl/suspect_marker.sv
module suspect_marker
  import suspect_mark_pkg::*;
#(
  parameter int NUM_PE  = 10,
  parameter int PERIOD  = 13,
  parameter int CHECKED = 3,
  parameter int CYC_W   = 16,
  localparam int PE_W   = idx_width(NUM_PE),
  localparam int IDX_W  = idx_width(CHECKED)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PE_W-1:0]  req_pe,
  input  logic [IDX_W-1:0] req_chk,
  input  logic [CYC_W-1:0] req_cycle,
  output logic             busy,
  output logic             tag_valid,
  output logic [PE_W-1:0]  tag_pe,
  output logic [CYC_W-1:0] tag_cycle,
  output logic             tag_last
);

  logic            rst_sync_n;
  logic [PE_W-1:0] reach;
  logic            req_ok;
  logic            walk_active;
  logic            walk_last;
  logic            start;

  sm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  sm_reach_table #(
    .PERIOD  (PERIOD),
    .CHECKED (CHECKED),
    .NUM_PE  (NUM_PE),
    .PE_W    (PE_W),
    .IDX_W   (IDX_W)
  ) u_reach (
    .chk_idx (req_chk),
    .det_pe  (req_pe),
    .reach   (reach),
    .req_ok  (req_ok)
  );

  assign start = req_valid && req_ok && !walk_active;

  sm_walker #(
    .PE_W  (PE_W),
    .CYC_W (CYC_W)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .start_pe    (req_pe),
    .start_cycle (req_cycle),
    .start_reach (reach),
    .active      (walk_active),
    .cur_pe      (tag_pe),
    .cur_cycle   (tag_cycle),
    .last        (walk_last)
  );

  assign busy      = walk_active;
  assign tag_valid = walk_active;
  assign tag_last  = walk_last;

endmodule

// File: rtl/suspect_marker_chk.sv
module suspect_marker_chk
  import suspect_mark_pkg::*;
#(
  parameter int NUM_PE  = 10,
  parameter int CHECKED = 3,
  parameter int CYC_W   = 16,
  localparam int PE_W   = idx_width(NUM_PE),
  localparam int IDX_W  = idx_width(CHECKED)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [PE_W-1:0]  req_pe,
  input logic [IDX_W-1:0] req_chk,
  input logic [CYC_W-1:0] req_cycle,
  input logic             busy,
  input logic             tag_valid,
  input logic [PE_W-1:0]  tag_pe,
  input logic [CYC_W-1:0] tag_cycle,
  input logic             tag_last
);

  logic good_req;
  assign good_req = req_valid && !busy &&
                    (int'(req_pe) < NUM_PE) && (int'(req_chk) < CHECKED);

  a_r1_first_tag: assert property (@(posedge clk) disable iff (!rst_n)
    good_req |=> tag_valid && tag_pe == $past(req_pe) && tag_cycle == $past(req_cycle));

  a_r3_diagonal_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_last) |=>
      tag_valid && tag_pe == $past(tag_pe) - 1'b1 && tag_cycle == $past(tag_cycle) - 1'b1);

  a_r4_last_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_last |=> !tag_valid);

  a_r4_last_with_tag: assert property (@(posedge clk) disable iff (!rst_n)
    tag_last |-> tag_valid);

  a_r5_last_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_pe == '0) |-> tag_last);

  a_r6_busy_holds_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tag_last) |=> busy);

  a_r7_bad_req_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && (int'(req_chk) >= CHECKED)) |=> !tag_valid);

endmodule

bind suspect_marker suspect_marker_chk #(
  .NUM_PE  (NUM_PE),
  .CHECKED (CHECKED),
  .CYC_W   (CYC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_pe    (req_pe),
  .req_chk   (req_chk),
  .req_cycle (req_cycle),
  .busy      (busy),
  .tag_valid (tag_valid),
  .tag_pe    (tag_pe),
  .tag_cycle (tag_cycle),
  .tag_last  (tag_last)
);

// File: tb/sim_suspect_marker.sv
`timescale 1ns/1ps
module sim_suspect_marker;

  localparam int NUM_PE  = 10;
  localparam int PERIOD  = 13;
  localparam int CHECKED = 3;
  localparam int CYC_W   = 16;
  localparam int PE_W    = 4;
  localparam int IDX_W   = 2;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [PE_W-1:0]  req_pe;
  logic [IDX_W-1:0] req_chk;
  logic [CYC_W-1:0] req_cycle;
  logic             busy;
  logic             tag_valid;
  logic [PE_W-1:0]  tag_pe;
  logic [CYC_W-1:0] tag_cycle;
  logic             tag_last;

  int checks;
  int fails;
  bit done_flag;

  suspect_marker #(
    .NUM_PE  (NUM_PE),
    .PERIOD  (PERIOD),
    .CHECKED (CHECKED),
    .CYC_W   (CYC_W)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_pe    (req_pe),
    .req_chk   (req_chk),
    .req_cycle (req_cycle),
    .busy      (busy),
    .tag_valid (tag_valid),
    .tag_pe    (tag_pe),
    .tag_cycle (tag_cycle),
    .tag_last  (tag_last)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Depth of the backward walk, from the requirement formula (R2, R5).
  function automatic int exp_depth(int pe, int pos);
    int cap;
    cap = (PERIOD + pos + 1 + CHECKED - 1) / CHECKED - 2;
    return (cap < pe) ? cap : pe;
  endfunction

  // Issue one report and check the whole walk; optionally present a
  // second report during the walk (R6).
  task automatic run_walk(input int pe, input int pos, input int cyc,
                          input string req, input bit intrude);
    int d;
    logic [CYC_W-1:0] ecyc;
    d = exp_depth(pe, pos);
    @(negedge clk);
    req_valid = 1'b1;
    req_pe    = PE_W'(pe);
    req_chk   = IDX_W'(pos);
    req_cycle = CYC_W'(cyc);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= d; k++) begin
      ecyc = CYC_W'(cyc - k);
      chk(tag_valid == 1'b1, req, "tag_valid", tag_valid, 1);
      chk(busy == 1'b1, "R6", "busy", busy, 1);
      chk(int'(tag_pe) == pe - k, req, "tag_pe", tag_pe, pe - k);
      chk(tag_cycle == ecyc, req, "tag_cycle", tag_cycle, ecyc);
      chk(tag_last == (k == d), "R4", "tag_last", tag_last, (k == d));
      if (intrude && k == 0) begin
        req_valid = 1'b1;
        req_pe    = 4'd3;
        req_chk   = 2'd0;
        req_cycle = 16'd50;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(tag_valid == 1'b0, "R4", "tag_valid after last", tag_valid, 0);
    chk(busy == 1'b0, "R6", "busy after last", busy, 0);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R8", "busy", busy, 0);
    chk(tag_valid == 1'b0, "R8", "tag_valid", tag_valid, 0);
    chk(tag_last == 1'b0, "R8", "tag_last", tag_last, 0);
  endtask

  task automatic t_invalid(input int pe, input int pos);
    @(negedge clk);
    req_valid = 1'b1;
    req_pe    = PE_W'(pe);
    req_chk   = IDX_W'(pos);
    req_cycle = 16'd77;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag_valid == 1'b0, "R7", "tag_valid", tag_valid, 0);
    chk(busy == 1'b0, "R7", "busy", busy, 0);
    @(negedge clk);
    chk(tag_valid == 1'b0, "R7", "tag_valid later", tag_valid, 0);
  endtask

  task automatic t_idle_after_intrude;
    for (int n = 0; n < 4; n++) begin
      chk(tag_valid == 1'b0, "R6", "no tag from dropped report", tag_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #200000;
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    fails     = 0;
    done_flag = 1'b0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_pe    = '0;
    req_chk   = '0;
    req_cycle = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    run_walk(8, 2, 100, "R2", 1'b0);  // R1 R2 R3: depth 4, elements 8..4
    run_walk(8, 0, 300, "R2", 1'b0);  // R2: depth 3
    run_walk(6, 1, 400, "R3", 1'b0);  // R3: depth 3
    run_walk(1, 2, 500, "R5", 1'b0);  // R5: saturated at element index
    run_walk(0, 2, 600, "R5", 1'b0);  // R5: single tag with last
    run_walk(9, 2, 1, "R3", 1'b0);    // R3: cycle wraps below zero
    run_walk(8, 2, 200, "R6", 1'b1);  // R6: report during walk ignored
    t_idle_after_intrude();
    t_invalid(2, 3);                  // R7: position out of range
    t_invalid(12, 0);                 // R7: element out of range
    run_walk(5, 0, 700, "R1", 1'b0);  // R1: accepted again after drops
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule